// File: doc/BRIEF.md
# Three-Channel Event Timer Comparator Bank

This block sits next to a free-running main counter, which it receives as an input, and raises interrupts when that counter reaches programmed match values. It has three comparator channels. Channel 0 is the full-featured one. It holds a 64-bit match value that software may narrow to 32 bits, and it can run periodically by adding a stored period to its match value each time it fires. Channels 1 and 2 hold 32-bit match values and fire once per programmed value.

Each channel has a configuration word, a match register and a sticky status flag. Software reaches them over a small single-cycle register bus: writes take effect at the clock edge, and reads are combinational. Each channel's level interrupt goes to one of a set of output lines, chosen by a 5-bit route field. When the global legacy input is high, channels 0 and 1 ignore their route fields and drive two fixed lines instead.

Top module: `evt_cmp_top`

## Requirements
- R1: After reset, every channel's interrupt enable, periodic flag, narrow flag and route are 0. All status flags and interrupt lines are low. Channel 0's match value is all ones (64 bits), and the match values of channels 1 and 2 are 0xFFFF_FFFF.
- R2: Bus address 2*c selects the configuration word of channel c, 2*c+1 its match register, and address 6 the status word. The configuration word reads back as: bit 2 interrupt enable, bit 3 periodic, bit 4 periodic-capable (constant), bit 5 64-bit-capable (constant), bit 8 narrow mode, bits 13:9 route. Bits 6 and 7 and all other bits read 0. Bits 4 and 5 read 1 on channel 0 and 0 on channels 1 and 2.
- R3: The route field stores any 5-bit value written to it, unchecked, and reads it back.
- R4: On channels 1 and 2 the periodic and narrow bits always read 0, and writes to them are ignored. On channel 0 both bits are read/write.
- R5: A channel fires in any cycle where its match value equals the main counter. Channel 0 in 64-bit mode compares all 64 bits. Channels 1 and 2, and channel 0 in narrow mode, compare only the low 32 bits. A firing sets the channel's status bit (bit c of the status word) at the next edge, and the bit stays set.
- R6: Writing the status word clears each status bit whose data bit is 1. Data bits of 0 leave status unchanged. A firing in the same cycle as a clear wins.
- R7: Interrupt line n is high exactly when some channel has its status set, its enable set, and an effective route equal to n. With enable clear, status is still set, but no line is driven. Routes of 24 or more drive no line.
- R8: While the legacy input is high, channel 0 routes to line 0 and channel 1 routes to line 8, whatever their route fields hold. Channel 2 always uses its route field.
- R9: When channel 0 is periodic, each firing adds the stored period to its match value. A channel that is not periodic keeps its match value until software writes it.
- R10: Writing channel 0's configuration with bit 6 and bit 3 both set arms a one-shot load. The next match-register write then updates both the match value and the period, and the arm clears. Bit 6 always reads 0 and does nothing on channels 1 and 2. A match write made while unarmed leaves the period unchanged.
- R11: Setting channel 0's narrow bit clears the upper 32 bits of its match value and of its period. They stay zero after the channel returns to 64-bit mode.
- R12: In narrow mode, a match write keeps only the low 32 bits, and the periodic add wraps within 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt_i | input | 64 | Main counter value |
| legacy_i | input | 1 | Legacy fixed-routing select for channels 0 and 1 |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 64 | Register write data |
| bus_rdata_o | output | 64 | Register read data (combinational) |
| irq_o | output | 24 | Level interrupt lines |

## Verification
The assertions assume that the bus makes at most one write per cycle, to a single register, and that the main counter is stable between edges. The period check also assumes that software does not rewrite the configuration in the cycle that channel 0 fires. The bench drives each input at the falling edge and issues bus writes one at a time. Before clearing status or reprogramming a channel, it parks the counter at a value no channel matches, so a one-shot channel does not keep refiring while the bench changes its state.

// File: rtl/evt_pkg.sv
package evt_pkg;
   localparam int ROUTE_W = 5;
   localparam int B_IEN   = 2;
   localparam int B_TYPE  = 3;
   localparam int B_PCAP  = 4;
   localparam int B_SIZE  = 5;
   localparam int B_VSET  = 6;
   localparam int B_M32   = 8;
   localparam int B_ROUTE = 9;
   localparam int IMG_W   = 16;

   typedef struct packed {
      logic [ROUTE_W-1:0] route;
      logic               m32;
      logic               periodic;
      logic               ien;
   } chan_cfg_t;

   function automatic logic [IMG_W-1:0] cfg_image(chan_cfg_t c, logic pcap, logic size);
      logic [IMG_W-1:0] v;
      v                        = '0;
      v[B_IEN]                 = c.ien;
      v[B_TYPE]                = c.periodic;
      v[B_PCAP]                = pcap;
      v[B_SIZE]                = size;
      v[B_M32]                 = c.m32;
      v[B_ROUTE +: ROUTE_W]    = c.route;
      return v;
   endfunction
endpackage

// File: rtl/evt_chan.sv
module evt_chan
   import evt_pkg::*;
#(
   parameter int CNT_W   = 64,
   parameter bit WIDE    = 1'b1,
   parameter bit PER_CAP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cfg_we_i,
   input  logic             cmp_we_i,
   input  logic             st_clr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output chan_cfg_t        cfg_o,
   output logic [CNT_W-1:0] cmp_o,
   output logic             fire_o,
   output logic             status_o
);
   localparam int               HALF      = CNT_W / 2;
   localparam logic [CNT_W-1:0] LOW_MASK  = {{HALF{1'b0}}, {HALF{1'b1}}};
   localparam logic [CNT_W-1:0] FULL_MASK = '1;
   localparam logic [CNT_W-1:0] CMP_INIT  = WIDE ? FULL_MASK : LOW_MASK;

   if (CNT_W < IMG_W || (CNT_W % 2) != 0) begin : g_bad_width
      $error("evt_chan: CNT_W must be even and at least %0d", IMG_W);
   end

   logic               ien_q;
   logic [ROUTE_W-1:0] route_q;
   logic               m32_q;
   logic               m32_rise;
   logic               per_q;
   logic               arm_q;
   logic [CNT_W-1:0]   period_q;
   logic [CNT_W-1:0]   cmp_q;
   logic               st_q;
   logic               narrow;
   logic [CNT_W-1:0]   mask;
   logic [CNT_W-1:0]   sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q   <= 1'b0;
         route_q <= '0;
      end else if (cfg_we_i) begin
         ien_q   <= wdata_i[B_IEN];
         route_q <= wdata_i[B_ROUTE +: ROUTE_W];
      end
   end

   if (WIDE) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        m32_q <= 1'b0;
         else if (cfg_we_i) m32_q <= wdata_i[B_M32];
      end
      assign m32_rise = cfg_we_i && wdata_i[B_M32] && !m32_q;

      AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         m32_q |-> (cmp_q[CNT_W-1:HALF] == '0)); // R11
   end else begin : g_narrow
      assign m32_q    = 1'b0;
      assign m32_rise = 1'b0;
   end

   assign narrow = m32_q || !WIDE;
   assign mask   = narrow ? LOW_MASK : FULL_MASK;
   assign fire_o = ((cnt_i ^ cmp_q) & mask) == '0;
   assign sum    = (cmp_q + period_q) & mask;

   if (PER_CAP) begin : g_periodic
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_q    <= 1'b0;
            arm_q    <= 1'b0;
            period_q <= '0;
         end else if (cfg_we_i) begin
            per_q <= wdata_i[B_TYPE];
            arm_q <= wdata_i[B_VSET] && wdata_i[B_TYPE];
            if (m32_rise) period_q <= period_q & LOW_MASK;
         end else if (cmp_we_i) begin
            arm_q <= 1'b0;
            if (arm_q) period_q <= wdata_i & mask;
         end
      end

      AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_we_i && !cfg_we_i) |=> !arm_q); // R10
      AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (fire_o && per_q && !cmp_we_i && !cfg_we_i)
         |=> (((cmp_q - $past(cmp_q)) & $past(mask)) == ($past(period_q) & $past(mask)))); // R9
   end else begin : g_oneshot
      assign per_q    = 1'b0;
      assign arm_q    = 1'b0;
      assign period_q = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cmp_q <= CMP_INIT;
      else if (cmp_we_i)         cmp_q <= wdata_i & mask;
      else if (m32_rise)         cmp_q <= cmp_q & LOW_MASK;
      else if (fire_o && per_q)  cmp_q <= sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= fire_o || (st_q && !st_clr_i);
   end

   AST_FIRE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> st_q); // R5
   AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (st_clr_i && !fire_o) |=> !st_q); // R6
   AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_q && !cmp_we_i && !m32_rise) |=> $stable(cmp_q)); // R9

   assign cfg_o.ien      = ien_q;
   assign cfg_o.periodic = per_q;
   assign cfg_o.m32      = m32_q;
   assign cfg_o.route    = route_q;
   assign cmp_o          = cmp_q;
   assign status_o       = st_q;
endmodule

// File: rtl/evt_route.sv
module evt_route
   import evt_pkg::*;
#(
   parameter int NCH    = 3,
   parameter int NLINES = 24,
   parameter int LEG0   = 0,
   parameter int LEG1   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NCH-1:0]         req_i,
   input  logic [NCH*ROUTE_W-1:0] route_i,
   input  logic                   legacy_i,
   output logic [NLINES-1:0]      lines_o
);
   localparam logic [ROUTE_W-1:0] L0 = ROUTE_W'(LEG0);
   localparam logic [ROUTE_W-1:0] L1 = ROUTE_W'(LEG1);

   if (NLINES < 1 || NLINES > (1 << ROUTE_W)) begin : g_bad_lines
      $error("evt_route: NLINES out of range");
   end
   if (LEG0 >= NLINES || LEG1 >= NLINES) begin : g_bad_leg
      $error("evt_route: legacy line outside NLINES");
   end

   logic [ROUTE_W-1:0] eff [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_eff
      if (c == 0) begin : g_leg0
         assign eff[c] = legacy_i ? L0 : route_i[c*ROUTE_W +: ROUTE_W];
      end else if (c == 1) begin : g_leg1
         assign eff[c] = legacy_i ? L1 : route_i[c*ROUTE_W +: ROUTE_W];
      end else begin : g_plain
         assign eff[c] = route_i[c*ROUTE_W +: ROUTE_W];
      end
   end

   for (genvar l = 0; l < NLINES; l++) begin : g_line
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int c = 0; c < NCH; c++) begin
            hit = hit | (req_i[c] && (eff[c] == ROUTE_W'(l)));
         end
      end
      assign lines_o[l] = hit;
   end

   AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (|lines_o) |-> (|req_i)); // R7
endmodule

// File: rtl/evt_cmp_top.sv
module evt_cmp_top
   import evt_pkg::*;
#(
   parameter int CNT_W     = 64,
   parameter int NUM_CH    = 3,
   parameter int NUM_LINES = 24,
   parameter int LEG0_LINE = 0,
   parameter int LEG1_LINE = 8,
   localparam int CH_AW    = $clog2(NUM_CH + 1),
   localparam int ADDR_W   = CH_AW + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     main_cnt_i,
   input  logic                 legacy_i,
   input  logic                 bus_wr_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [CNT_W-1:0]     bus_wdata_i,
   output logic [CNT_W-1:0]     bus_rdata_o,
   output logic [NUM_LINES-1:0] irq_o
);
   localparam logic [CH_AW-1:0] STAT_IDX = CH_AW'(NUM_CH);

   if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_ch
      $error("evt_cmp_top: NUM_CH out of range");
   end

   logic [CH_AW-1:0]         sel_ch;
   logic                     is_cmp;
   logic                     stat_wr;
   chan_cfg_t                cfg   [NUM_CH];
   logic [CNT_W-1:0]         cmpv  [NUM_CH];
   logic [CNT_W-1:0]         img   [NUM_CH];
   logic [NUM_CH-1:0]        fire;
   logic [NUM_CH-1:0]        status;
   logic [NUM_CH-1:0]        req;
   logic [NUM_CH*ROUTE_W-1:0] routes;

   assign sel_ch  = bus_addr_i[ADDR_W-1:1];
   assign is_cmp  = bus_addr_i[0];
   assign stat_wr = bus_wr_i && (sel_ch == STAT_IDX) && !is_cmp;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam bit IS_MAIN = (i == 0);
      logic sel;
      assign sel = (sel_ch == CH_AW'(i));

      evt_chan #(
         .CNT_W  (CNT_W),
         .WIDE   (IS_MAIN),
         .PER_CAP(IS_MAIN)
      ) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt_i    (main_cnt_i),
         .cfg_we_i (bus_wr_i && sel && !is_cmp),
         .cmp_we_i (bus_wr_i && sel && is_cmp),
         .st_clr_i (stat_wr && bus_wdata_i[i]),
         .wdata_i  (bus_wdata_i),
         .cfg_o    (cfg[i]),
         .cmp_o    (cmpv[i]),
         .fire_o   (fire[i]),
         .status_o (status[i])
      );

      assign img[i]                      = CNT_W'(cfg_image(cfg[i], IS_MAIN, IS_MAIN));
      assign req[i]                      = status[i] && cfg[i].ien;
      assign routes[i*ROUTE_W +: ROUTE_W] = cfg[i].route;
   end

   always_comb begin
      bus_rdata_o = '0;
      if (sel_ch == STAT_IDX) begin
         if (!is_cmp) bus_rdata_o = CNT_W'(status);
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ch == CH_AW'(i)) bus_rdata_o = is_cmp ? cmpv[i] : img[i];
         end
      end
   end

   evt_route #(
      .NCH   (NUM_CH),
      .NLINES(NUM_LINES),
      .LEG0  (LEG0_LINE),
      .LEG1  (LEG1_LINE)
   ) route_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .route_i (routes),
      .legacy_i(legacy_i),
      .lines_o (irq_o)
   );

   AST_STATUS_ONLY_BY_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire[0] && !status[0]) |=> !status[0]); // R5
endmodule

// File: tb/evt_cmp_top_tb.sv
module evt_cmp_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = 64'd1;
   logic        legacy = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic [63:0] rdata;
   logic [23:0] irq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   evt_cmp_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .main_cnt_i (cnt),
      .legacy_i   (legacy),
      .bus_wr_i   (wr),
      .bus_addr_i (addr),
      .bus_wdata_i(wdata),
      .bus_rdata_o(rdata),
      .irq_o      (irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [63:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   task automatic set_cnt(input logic [63:0] v);
      @(negedge clk);
      cnt = v;
   endtask

   task automatic irq_chk(input string req, input logic [23:0] exp);
      chk(req, {40'd0, irq}, {40'd0, exp});
   endtask

   task automatic t_reset;
      rd_chk("R1 ch0 cfg", 3'd0, 64'h30);
      rd_chk("R1 ch1 cfg", 3'd2, 64'h0);
      rd_chk("R1 ch2 cfg", 3'd4, 64'h0);
      rd_chk("R1 ch0 match", 3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R1 ch1 match", 3'd3, 64'h0000_0000_FFFF_FFFF);
      rd_chk("R1 status", 3'd6, 64'h0);
      irq_chk("R1 irq", 24'h0);
   endtask

   task automatic t_cfg_fields;
      wr_reg(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R2 ch0 all-ones image", 3'd0, 64'h3F3C);
      wr_reg(3'd0, 64'h0);
      rd_chk("R11 upper cleared stays", 3'd1, 64'h0000_0000_FFFF_FFFF);
      wr_reg(3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R4 ch1 type/narrow hardwired", 3'd2, 64'h3E04);
      wr_reg(3'd4, 64'h0000_0000_0000_0148);
      rd_chk("R10 ch2 value-set ignored", 3'd4, 64'h0);
      wr_reg(3'd2, 64'd5 << 9);
      rd_chk("R3 route 5 stored", 3'd2, 64'h0A00);
   endtask

   task automatic t_fire_basic;
      wr_reg(3'd2, 64'h2804);
      wr_reg(3'd3, 64'h100);
      set_cnt(64'hAB_0000_0100);
      rd_chk("R5 ch1 low-32 fire", 3'd6, 64'h2);
      irq_chk("R7 line 20", 24'h1 << 20);
      set_cnt(64'd1);
      rd_chk("R5 status sticky", 3'd6, 64'h2);
      wr_reg(3'd6, 64'h0);
      rd_chk("R6 zero write no effect", 3'd6, 64'h2);
      wr_reg(3'd6, 64'h2);
      rd_chk("R6 clear", 3'd6, 64'h0);
      irq_chk("R6 irq dropped", 24'h0);
   endtask

   task automatic t_enable_gate;
      wr_reg(3'd4, 64'h1600);
      wr_reg(3'd5, 64'h200);
      set_cnt(64'h200);
      rd_chk("R7 status without enable", 3'd6, 64'h4);
      irq_chk("R7 no irq when disabled", 24'h0);
      set_cnt(64'd1);
      wr_reg(3'd4, 64'h1604);
      irq_chk("R7 line 11 after enable", 24'h1 << 11);
      wr_reg(3'd6, 64'h4);
      wr_reg(3'd4, 64'h4 | (64'd30 << 9));
      wr_reg(3'd5, 64'h280);
      set_cnt(64'h280);
      rd_chk("R7 route 30 status", 3'd6, 64'h4);
      irq_chk("R7 route 30 drives nothing", 24'h0);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h4);
   endtask

   task automatic t_wide;
      wr_reg(3'd0, 64'h2C04);
      wr_reg(3'd1, 64'h1_0000_0300);
      set_cnt(64'h300);
      rd_chk("R5 64-bit no partial match", 3'd6, 64'h0);
      set_cnt(64'h1_0000_0300);
      rd_chk("R5 64-bit match", 3'd6, 64'h1);
      irq_chk("R7 line 22", 24'h1 << 22);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h1);
      wr_reg(3'd0, 64'h2D04);
      rd_chk("R11 narrow clears upper", 3'd1, 64'h300);
      wr_reg(3'd1, 64'h5_0000_0400);
      rd_chk("R12 narrow write low only", 3'd1, 64'h400);
      set_cnt(64'h7_0000_0400);
      rd_chk("R5 narrow compare", 3'd6, 64'h1);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h1);
      wr_reg(3'd0, 64'h2C04);
      rd_chk("R11 zeros kept in 64-bit", 3'd1, 64'h400);
   endtask

   task automatic t_legacy;
      wr_reg(3'd3, 64'h400);
      @(negedge clk);
      legacy = 1'b1;
      set_cnt(64'h400);
      @(negedge clk);
      irq_chk("R8 fixed lines 0 and 8", 24'h000101);
      legacy = 1'b0;
      #1;
      irq_chk("R8 route fields again", (24'h1 << 22) | (24'h1 << 20));
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h3);
      rd_chk("R6 both cleared", 3'd6, 64'h0);
   endtask

   task automatic t_periodic;
      wr_reg(3'd0, 64'h2A4C);
      rd_chk("R10 value-set reads 0", 3'd0, 64'h2A3C);
      wr_reg(3'd1, 64'h1000);
      wr_reg(3'd1, 64'h1800);
      set_cnt(64'h1800);
      rd_chk("R9 reload adds period", 3'd1, 64'h2800);
      rd_chk("R9 periodic status", 3'd6, 64'h1);
      irq_chk("R7 line 21", 24'h1 << 21);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h1);
      set_cnt(64'h2800);
      rd_chk("R10 period kept after unarmed write", 3'd1, 64'h3800);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h1);
      wr_reg(3'd0, 64'h2B4C);
      wr_reg(3'd1, 64'hF000_0000);
      set_cnt(64'hF000_0000);
      rd_chk("R12 narrow reload wraps", 3'd1, 64'hE000_0000);
      set_cnt(64'd1);
      wr_reg(3'd6, 64'h1);
      wr_reg(3'd0, 64'h0);
      rd_chk("R6 final status", 3'd6, 64'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cfg_fields();
      t_fire_basic();
      t_enable_gate();
      t_wide();
      t_legacy();
      t_periodic();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule